// File: doc/BRIEF.md
# Serial EEPROM Loader with Autosize

This block reads a three-wire serial EEPROM after reset. It has a chip-select output, a shift-clock output, a data-in line toward the device and a data-out line from it. The block first runs a probe read to find whether the device decodes 6 or 8 address bits. It then reads every word of the device in ascending order. The first sixteen words go into a small register file, and all words are added into a 16-bit running checksum. From the first three cached words it forms a 48-bit station address. When the sequence finishes it raises a one-cycle done strobe and reports the detected size and whether the checksum matched.

A pulse on `start` runs the whole sequence again once the block is idle. The width of each serial clock phase comes from the `HALF` parameter, counted in system clock cycles. The default gives 2 us phases at a 200 MHz system clock. All words are read framed with the detected address width. Each serial transaction is 28 bit slots long, so the same frame carries both the probe and the ordinary reads.

Top module: `eeprom_loader`

## Requirements
- R1: After reset is released, and after a `start` pulse while idle, `busy` is high and the whole sequence runs. `done` is high for exactly one cycle, in the first cycle in which `busy` is low. A `start` pulse while `busy` is high has no effect. During reset `busy` is 1, and `done`, `ee_cs`, `ee_sk` and `sum_ok` are 0.
- R2: Within a transaction, `ee_sk` is high or low for exactly `HALF` system cycles per phase, and only while `ee_cs` is high. `ee_di` changes only while `ee_sk` is low. Each transaction gives 29 rising edges of `ee_sk`: one leading pulse with `ee_di` low, then 28 bit slots.
- R3: The 28 slot values on `ee_di` go out most significant first. For 8-bit framing they are 0,1,1,0, then address bits a7..a0, then 16 zeros. For 6-bit framing they are 0,0,0,1,1,0, then a5..a0, then 16 zeros.
- R4: `ee_do` is sampled in the last system cycle of each high phase and shifted in, so that slot k lands at result bit 27-k. The word read is the last 16 slots, most significant first.
- R5: The first transaction of a run is an 8-bit-framed read of address 0. `big_part` becomes 1 when result bits 27 down to 17 are all 1. The device then has 256 words read with 8-bit framing. Otherwise it has 64 words read with 6-bit framing.
- R6: After the probe, words 0 to N-1 are read in ascending order, one transaction each, so a run has exactly N+1 transactions.
- R7: At `done`, `sum_ok` is 1 only when the 16-bit wraparound sum of all N words equals 0xBABA. A new run clears it.
- R8: `rd_data` shows the cached word selected by `rd_addr`, for words 0 to 15, combinationally.
- R9: `station_addr[47:40]` is the low byte of word 0 and `[39:32]` is its high byte. Bits `[31:16]` hold word 1 and bits `[15:0]` hold word 2 in the same order, low byte first.
- R10: A transaction ends with `ee_sk` held low for `HALF` cycles while `ee_cs` stays high. After that `ee_cs` falls and stays low for at least `HALF` cycles before the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Re-run request, honoured only while idle |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| big_part | output | 1 | 1 = 256-word device, 0 = 64-word device |
| sum_ok | output | 1 | Checksum matched 0xBABA |
| station_addr | output | 48 | Station address from words 0 to 2 |
| rd_addr | input | 4 | Cache read index |
| rd_data | output | 16 | Cached word at `rd_addr` |

## Verification
A wrong phase or slot count in the serial engine shows on the very next transaction: the number of shift-clock pulses inside chip select changes, or the data-in pattern slips by one slot. A fault in address stepping or in size detection shows as the wrong transaction count or framing within one run. It also shows at `done` as a wrong `big_part`. A sampling or shift error in the result register shows only at `done`, through corrupted cached words, a wrong station address and a wrong `sum_ok`. The bench therefore compares every transaction's framing as it happens and checks the stored contents after each run.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

  // Serial engine phases
  typedef enum logic [2:0] {
    PH_IDLE, PH_SEL, PH_LEAD, PH_LO, PH_HI, PH_TAIL, PH_REL
  } ph_t;

  // Sequencer states
  typedef enum logic [2:0] {
    SQ_BOOT, SQ_IDLE, SQ_PROBE, SQ_PWAIT, SQ_READ, SQ_RWAIT, SQ_FIN
  } sq_t;

  // Start bit followed by the two-bit read opcode
  localparam logic [2:0] RD_OP = 3'b110;

endpackage

// File: rtl/eeld_serial.sv
module eeld_serial
  import eeld_pkg::*;
#(
  parameter int HALF  = 400,
  parameter int FRAME = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [FRAME-1:0] cmd,
  input  logic             ee_do,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  output logic [FRAME-1:0] res,
  output logic             fin
);

  localparam int TW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam int SW = $clog2(FRAME);
  localparam logic [TW-1:0] TICK_END = TW'(HALF - 1);
  localparam logic [SW-1:0] SLOT_END = SW'(FRAME - 1);

  ph_t              ph_q, ph_n;
  logic [TW-1:0]    tick_q, tick_n;
  logic [SW-1:0]    slot_q, slot_n;
  logic [FRAME-1:0] sh_q, sh_n, res_q, res_n;
  logic             cs_q, cs_n, sk_q, sk_n, di_q, di_n, fin_q, fin_n;
  logic             tick_end;

  assign tick_end = (tick_q == TICK_END);

  always_comb begin
    ph_n   = ph_q;
    tick_n = tick_q;
    slot_n = slot_q;
    sh_n   = sh_q;
    res_n  = res_q;
    fin_n  = 1'b0;
    if (ph_q == PH_IDLE) begin
      tick_n = '0;
      if (go) begin
        ph_n  = PH_SEL;
        sh_n  = cmd;
        res_n = '0;
      end
    end else if (!tick_end) begin
      tick_n = tick_q + 1'b1;
    end else begin
      tick_n = '0;
      case (ph_q)
        PH_SEL:  ph_n = PH_LEAD;
        PH_LEAD: begin
          ph_n   = PH_LO;
          slot_n = '0;
        end
        PH_LO:   ph_n = PH_HI;
        PH_HI: begin
          res_n = {res_q[FRAME-2:0], ee_do};
          sh_n  = {sh_q[FRAME-2:0], 1'b0};
          if (slot_q == SLOT_END) begin
            ph_n = PH_TAIL;
          end else begin
            slot_n = slot_q + 1'b1;
            ph_n   = PH_LO;
          end
        end
        PH_TAIL: ph_n = PH_REL;
        PH_REL: begin
          ph_n  = PH_IDLE;
          fin_n = 1'b1;
        end
        default: ph_n = PH_IDLE;
      endcase
    end
    cs_n = (ph_n == PH_SEL) || (ph_n == PH_LEAD) || (ph_n == PH_LO) ||
           (ph_n == PH_HI) || (ph_n == PH_TAIL);
    sk_n = (ph_n == PH_LEAD) || (ph_n == PH_HI);
    di_n = ((ph_n == PH_LO) || (ph_n == PH_HI)) ? sh_n[FRAME-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      tick_q <= '0;
      slot_q <= '0;
      sh_q   <= '0;
      res_q  <= '0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      di_q   <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      tick_q <= tick_n;
      slot_q <= slot_n;
      sh_q   <= sh_n;
      res_q  <= res_n;
      cs_q   <= cs_n;
      sk_q   <= sk_n;
      di_q   <= di_n;
      fin_q  <= fin_n;
    end
  end

  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_di = di_q;
  assign res   = res_q;
  assign fin   = fin_q;

  // Checker state: cycles for which the shift clock has held its level
  logic          sk_d;
  logic [TW:0]   hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_d   <= 1'b0;
      hold_q <= (TW+1)'(HALF);
    end else begin
      sk_d <= sk_q;
      if (sk_q != sk_d)                 hold_q <= (TW+1)'(1);
      else if (hold_q < (TW+1)'(HALF))  hold_q <= hold_q + 1'b1;
    end
  end

  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ee_sk) |-> hold_q >= (TW+1)'(HALF));
  a_r2_sk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  a_r2_di_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  a_r10_cs_after_sk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (!ee_sk && !$past(ee_sk)));

endmodule

// File: rtl/eeld_cache.sv
module eeld_cache #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [47:0]   mac
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we && (waddr == AW'(i))) mem_q[i] <= wdata;
      end
    end
  end

  assign rdata = mem_q[raddr];

  // Station address: three words, low byte of each first
  for (genvar g = 0; g < 3; g++) begin : g_mac
    assign mac[47-16*g -: 8] = mem_q[g][7:0];
    assign mac[39-16*g -: 8] = mem_q[g][15:8];
  end

endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
  import eeld_pkg::*;
#(
  parameter int          HALF        = 400,
  parameter int          SMALL_AW    = 6,
  parameter int          BIG_AW      = 8,
  parameter int          DW          = 16,
  parameter int          CACHE_WORDS = 16,
  parameter logic [15:0] MAGIC       = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ee_do,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  output logic        busy,
  output logic        done,
  output logic        big_part,
  output logic        sum_ok,
  output logic [47:0] station_addr,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data
);

  localparam int FRAME     = 1 + 3 + BIG_AW + DW;
  localparam int SMALL_PAD = FRAME - 3 - SMALL_AW - DW;
  localparam int CAW       = $clog2(CACHE_WORDS);
  localparam logic [BIG_AW-1:0] BIG_LAST   = '1;
  localparam logic [BIG_AW-1:0] SMALL_LAST = BIG_AW'((1 << SMALL_AW) - 1);
  localparam logic [FRAME-1:0]  PROBE_CMD  = {1'b0, RD_OP, {BIG_AW{1'b0}}, {DW{1'b0}}};

  sq_t               sq_q, sq_n;
  logic [BIG_AW-1:0] addr_q, addr_n;
  logic [DW-1:0]     sum_q, sum_n;
  logic              big_q, big_n, ok_q, ok_n, done_q, done_n;
  logic              go, fin, cache_we;
  logic [FRAME-1:0]  cmd, res;
  logic [BIG_AW-1:0] last_addr;

  assign last_addr = big_q ? BIG_LAST : SMALL_LAST;

  always_comb begin
    sq_n   = sq_q;
    addr_n = addr_q;
    sum_n  = sum_q;
    big_n  = big_q;
    ok_n   = ok_q;
    done_n = 1'b0;
    go     = 1'b0;
    cmd    = PROBE_CMD;
    case (sq_q)
      SQ_BOOT: sq_n = SQ_PROBE;
      SQ_IDLE: begin
        if (start) begin
          sq_n = SQ_PROBE;
          ok_n = 1'b0;
        end
      end
      SQ_PROBE: begin
        go     = 1'b1;
        sum_n  = '0;
        addr_n = '0;
        sq_n   = SQ_PWAIT;
      end
      SQ_PWAIT: begin
        if (fin) begin
          big_n = &res[FRAME-1:DW+1];
          sq_n  = SQ_READ;
        end
      end
      SQ_READ: begin
        go   = 1'b1;
        cmd  = big_q ? {1'b0, RD_OP, addr_q, {DW{1'b0}}}
                     : {{SMALL_PAD{1'b0}}, RD_OP, addr_q[SMALL_AW-1:0], {DW{1'b0}}};
        sq_n = SQ_RWAIT;
      end
      SQ_RWAIT: begin
        if (fin) begin
          sum_n = sum_q + res[DW-1:0];
          if (addr_q == last_addr) begin
            sq_n = SQ_FIN;
          end else begin
            addr_n = addr_q + 1'b1;
            sq_n   = SQ_READ;
          end
        end
      end
      SQ_FIN: begin
        ok_n   = (sum_q == MAGIC);
        done_n = 1'b1;
        sq_n   = SQ_IDLE;
      end
      default: sq_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_BOOT;
      addr_q <= '0;
      sum_q  <= '0;
      big_q  <= 1'b0;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sq_q   <= sq_n;
      addr_q <= addr_n;
      sum_q  <= sum_n;
      big_q  <= big_n;
      ok_q   <= ok_n;
      done_q <= done_n;
    end
  end

  assign cache_we = (sq_q == SQ_RWAIT) && fin &&
                    ({1'b0, addr_q} < (BIG_AW+1)'(CACHE_WORDS));

  eeld_serial #(.HALF(HALF), .FRAME(FRAME)) u_serial (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .cmd   (cmd),
    .ee_do (ee_do),
    .ee_cs (ee_cs),
    .ee_sk (ee_sk),
    .ee_di (ee_di),
    .res   (res),
    .fin   (fin)
  );

  eeld_cache #(.DEPTH(CACHE_WORDS), .DW(DW)) u_cache (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cache_we),
    .waddr (addr_q[CAW-1:0]),
    .wdata (res[DW-1:0]),
    .raddr (rd_addr),
    .rdata (rd_data),
    .mac   (station_addr)
  );

  assign busy     = (sq_q != SQ_IDLE);
  assign done     = done_q;
  assign big_part = big_q;
  assign sum_ok   = ok_q;

  a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r7_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_ok) |-> done);
  a_r5_size_moves_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(big_part) |-> busy);
  a_r6_fin_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (sq_q == SQ_PWAIT || sq_q == SQ_RWAIT));
  a_r4_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && sq_q == SQ_RWAIT) |-> !res[DW]);

endmodule

// File: tb/tb_eeprom_loader.sv
`timescale 1ns/1ps
module tb_eeprom_loader;

  localparam int HALF_T = 2;
  localparam int CLK_NS = 5;
  localparam int LIMIT  = 150000;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b1;
  logic        busy, done, big_part, sum_ok;
  logic [47:0] station_addr;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  eeprom_loader #(.HALF(HALF_T)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .busy(busy), .done(done), .big_part(big_part), .sum_ok(sum_ok),
    .station_addr(station_addr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Behavioural EEPROM
  logic [15:0] mem [256];
  int          m_aw = 6;
  int          m_st = 0, m_cnt = 0;
  logic [7:0]  m_a = '0;
  logic [15:0] m_w = '0;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      m_st = 0; m_cnt = 0; ee_do = 1'b1;
    end else begin
      case (m_st)
        0: if (ee_di) begin m_st = 1; m_cnt = 0; end
        1: begin
          m_cnt++;
          if (m_cnt == 2) begin m_st = 2; m_cnt = 0; m_a = '0; end
        end
        2: begin
          m_a = {m_a[6:0], ee_di};
          m_cnt++;
          if (m_cnt == m_aw) begin
            m_st = 3; m_cnt = 0; ee_do = 1'b0; m_w = mem[m_a];
          end
        end
        default: begin
          if (m_cnt < 16) begin ee_do = m_w[15-m_cnt]; m_cnt++; end
          else ee_do = 1'b1;
        end
      endcase
    end
  end

  // Transaction monitor
  int          tx_idx = 0, run_base = 0, cmd_bad = 0, tail_bad = 0, pulses = 0, k_mon = 0;
  logic [28:0] cap = '0;
  time         sk_fall_t = 0;

  function automatic logic [27:0] exp_cmd(input int k);
    logic [7:0] w;
    if (k == 0) return {1'b0, 3'b110, 8'h00, 16'h0000};
    w = 8'(k - 1);
    if (m_aw == 8) return {1'b0, 3'b110, w, 16'h0000};
    return {3'b000, 3'b110, w[5:0], 16'h0000};
  endfunction

  always @(negedge ee_sk) sk_fall_t = $time;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      k_mon = tx_idx - run_base;
      if (pulses != 29 || cap != {1'b0, exp_cmd(k_mon)}) cmd_bad++;
      if (ee_sk || ($time - sk_fall_t) < HALF_T * CLK_NS) tail_bad++;
      tx_idx++; pulses = 0; cap = '0;
    end else begin
      pulses++; cap = {cap[27:0], ee_di};
    end
  end

  // Clocked line monitor: phase lengths and data-in stability
  int   di_bad = 0, half_bad = 0, run_len = 100, done_cnt = 0;
  logic sk_p = 1'b0, di_p = 1'b0;
  always @(negedge clk) begin
    if (ee_sk && sk_p && ee_di != di_p) di_bad++;
    if (ee_sk != sk_p) begin
      if (run_len < HALF_T) half_bad++;
      run_len = 1;
    end else run_len++;
    sk_p = ee_sk; di_p = ee_di;
  end
  always @(posedge clk) if (done) done_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int aw, input bit bad);
    int n;
    logic [15:0] s;
    n = 1 << aw;
    s = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 4660) ^ (i << 5));
    for (int i = 0; i < n - 1; i++) s = s + mem[i];
    mem[n-1] = 16'hBABA - s + 16'(bad);
    m_aw = aw;
  endtask

  task automatic t_reset_state();
    chk(busy == 1'b1, "R1 busy in reset", 64'(busy), 1);
    chk(done == 1'b0, "R1 done in reset", 64'(done), 0);
    chk(ee_cs == 1'b0 && ee_sk == 1'b0, "R1 lines idle in reset", {ee_cs, ee_sk}, 0);
    chk(sum_ok == 1'b0, "R1 R7 sum_ok in reset", 64'(sum_ok), 0);
  endtask

  task automatic t_run(input string name, input int aw, input bit use_start, input bit poke);
    int n, d0, c0, di0, h0, t0;
    logic [15:0] s;
    logic [47:0] mac_e;
    n = 1 << aw;
    d0 = done_cnt; c0 = cmd_bad; di0 = di_bad; h0 = half_bad; t0 = tail_bad;
    run_base = tx_idx;
    s = '0;
    for (int i = 0; i < n; i++) s = s + mem[i];
    mac_e = {mem[0][7:0], mem[0][15:8], mem[1][7:0], mem[1][15:8], mem[2][7:0], mem[2][15:8]};
    $display("scenario %s", name);
    if (use_start) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy == 1'b1, "R1 busy after start", 64'(busy), 1);
    end
    if (poke) begin
      repeat (600) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done && cyc < LIMIT) @(negedge clk);
    if (!done) return;
    chk(busy == 1'b0, "R1 busy low at done", 64'(busy), 0);
    chk(big_part == (aw == 8), "R5 size detect", 64'(big_part), 64'(aw == 8));
    chk(sum_ok == (s == 16'hBABA), "R7 checksum flag", 64'(sum_ok), 64'(s == 16'hBABA));
    @(negedge clk);
    chk(done == 1'b0, "R1 done one cycle", 64'(done), 0);
    chk(done_cnt - d0 == 1, "R1 single done per run", 64'(done_cnt - d0), 1);
    chk(tx_idx - run_base == n + 1, "R6 transaction count", 64'(tx_idx - run_base), 64'(n + 1));
    chk(cmd_bad == c0, "R3 command framing", 64'(cmd_bad - c0), 0);
    chk(di_bad == di0 && half_bad == h0, "R2 slot timing", 64'(di_bad - di0 + half_bad - h0), 0);
    chk(tail_bad == t0, "R10 transaction end", 64'(tail_bad - t0), 0);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 4'(i);
      #1;
      chk(rd_data == mem[i], "R4 R8 cached word", 64'(rd_data), 64'(mem[i]));
    end
    chk(station_addr == mac_e, "R9 station address", 64'(station_addr), 64'(mac_e));
  endtask

  initial begin
    wait (cyc >= LIMIT + 1000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_addr = '0;
    fill(6, 1'b0);
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_run("boot_small_good", 6, 1'b0, 1'b0);
    fill(8, 1'b0);
    t_run("start_big_good_with_ignored_start", 8, 1'b1, 1'b1);
    fill(6, 1'b1);
    t_run("start_small_bad_sum", 6, 1'b1, 1'b0);
    if (cyc >= LIMIT) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule